// File: doc/BRIEF.md
# I2C Register Slave with Bus Watchdog

This block is the serial front end of a small register file on a two-wire bus. A fast system clock oversamples the clock and data lines. The block detects START and STOP, compares a 7-bit device address and shifts bytes MSB first. It pulls the data line low through an open-drain enable when it acknowledges a byte or sends a zero bit.

In a write, the first byte after the address becomes a register pointer. That pointer persists across transactions. Each following data byte is stored at the pointer, and the pointer then advances. A read starts at the stored pointer and advances the same way. The pointer wraps to zero past the last register.

A watchdog counts system clock cycles since the last clock-line edge or START. If the count runs out, the transfer is dropped and the data line is freed at once. The block then ignores the bus until the next START. Bit 0 of a configuration register turns this watchdog on or off.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0, the configuration register (index `CFG_IDX`, default 0) holds `CFG_RESET` (default 0x01), and every other register holds 0x00.
- R2: A byte after START whose upper 7 bits equal `DEV_ADDR` is acknowledged (data line low on the 9th clock pulse). Any other address is not acknowledged, and the bus is then ignored until the next START.
- R3: Bytes move MSB first. The receiver drives the acknowledge on the 9th clock pulse. The block changes its data drive only while the clock line is low, and STOP ends any transfer and releases the data line.
- R4: In a write (address bit 0 = 0), the first byte is stored as the pointer. Each later byte is written to the register at the pointer, is acknowledged, and advances the pointer by one.
- R5: A write that ends with STOP right after the pointer byte changes no register, but the pointer keeps the new value.
- R6: A read (address bit 0 = 1) returns the register at the stored pointer and advances the pointer after each byte. The pointer carries over into later transactions.
- R7: Advancing from `NUM_REGS-1` wraps the pointer to 0, for both writes and reads.
- R8: Writes to a pointer at or beyond `NUM_REGS` are acknowledged and discarded. Reads there return 0x00, and the next advance wraps the pointer to 0.
- R9: When the master does not acknowledge a read byte, the block stops driving the data line.
- R10: With the watchdog enabled, a gap of `TIMEOUT_CYCLES` system cycles with no clock-line edge and no START aborts the transfer and releases the data line.
- R11: After a watchdog abort, clock and data activity is ignored (no acknowledge, no drive, no register write) until a START.
- R12: With bit 0 of the configuration register cleared, a stalled transfer is never aborted and keeps its data drive.
- R13: A START that arrives in the same cycle as a watchdog expiry, or in the cycles next to it, begins a new transaction that is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| regs_o | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
The watchdog expiry and START detection can fall in the same system cycle. Both come out of the same synchronizer, so the bench can place one against the other. After a clock-line rise with no further edges, the bench drops the data line at several offsets around the expiry count, from a few cycles before to a few cycles after. It then sends a read address. In every case the address must be acknowledged and the byte at the pointer returned, which shows that START wins over the abort and restarts the watchdog.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e  st;
        logic [2:0]  bits;
        logic        full;
        logic [7:0]  sh;
        logic [7:0]  ptr;
        logic        rw;
        logic        oe;
        logic        nack;
    } slv_ctl_t;

    // Pointer advance with wrap after the last implemented register
    function automatic logic [7:0] ptr_next(input logic [7:0] p, input int unsigned n);
        return (p >= 8'(n - 1)) ? 8'd0 : p + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    localparam int W = SYNC_STAGES + 1;

    logic [W-1:0] scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[W-2:0], scl_i};
        sda_d = {sda_q[W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    // Stage W-2 is the settled level, stage W-1 the previous one
    assign scl_o    = scl_q[W-2];
    assign sda_o    = sda_q[W-2];
    assign scl_rise =  scl_q[W-2] & ~scl_q[W-1];
    assign scl_fall = ~scl_q[W-2] &  scl_q[W-1];
    assign start_o  = scl_q[W-2] & scl_q[W-1] & ~sda_q[W-2] &  sda_q[W-1];
    assign stop_o   = scl_q[W-2] & scl_q[W-1] &  sda_q[W-2] & ~sda_q[W-1];
endmodule

// File: rtl/i2c_bus_watchdog.sv
module i2c_bus_watchdog #(
    parameter int LIMIT = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic kick,
    input  logic enable,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!active || kick)    cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = active && enable && !kick && (cnt_q == LAST);
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int         NUM_REGS  = 8,
    parameter int         CFG_IDX   = 0,
    parameter logic [7:0] CFG_RESET = 8'h01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic                  cfg_timeout_en,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
        localparam logic [7:0] RV = (g == CFG_IDX) ? CFG_RESET : 8'h00;
        logic [7:0] r_d, r_q;
        always_comb r_d = (wr_en && wr_addr == 8'(g)) ? wr_data : r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= RV;
            else        r_q <= r_d;
        end
        assign regs_flat[g*8 +: 8] = r_q;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == 8'(i)) rd_data = regs_flat[i*8 +: 8];
    end

    assign cfg_timeout_en = regs_flat[CFG_IDX*8];
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR       = 7'h2A,
    parameter int         NUM_REGS       = 8,
    parameter int         CFG_IDX        = 0,
    parameter logic [7:0] CFG_RESET      = 8'h01,
    parameter int         TIMEOUT_CYCLES = 2_000_000,
    parameter int         SYNC_STAGES    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    slv_ctl_t   ctl_d, ctl_q;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_seen, stop_seen;
    logic       wd_expire, cfg_en, wr_en;
    logic [7:0] rd_data;
    logic       in_rack;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_o(start_seen), .stop_o(stop_seen)
    );

    i2c_bus_watchdog #(.LIMIT(TIMEOUT_CYCLES)) wd_i (
        .clk(clk), .rst_n(rst_n),
        .active(ctl_q.st != ST_IDLE),
        .kick(scl_rise | scl_fall | start_seen),
        .enable(cfg_en),
        .expire(wd_expire)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .CFG_IDX(CFG_IDX), .CFG_RESET(CFG_RESET)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(ctl_q.ptr), .wr_data(ctl_q.sh),
        .rd_addr(ctl_q.ptr), .rd_data(rd_data),
        .cfg_timeout_en(cfg_en), .regs_flat(regs_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        if (start_seen) begin
            ctl_d.st   = ST_ADDR;
            ctl_d.bits = '0;
            ctl_d.full = 1'b0;
            ctl_d.oe   = 1'b0;
        end else if (stop_seen || wd_expire) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.bits = '0;
            ctl_d.full = 1'b0;
            ctl_d.oe   = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        ctl_d.sh   = {ctl_q.sh[6:0], sda_s};
                        ctl_d.bits = ctl_q.bits + 3'd1;
                        if (ctl_q.bits == 3'd7) ctl_d.full = 1'b1;
                    end else if (scl_fall && ctl_q.full) begin
                        ctl_d.full = 1'b0;
                        if (ctl_q.st == ST_ADDR) begin
                            if (ctl_q.sh[7:1] == DEV_ADDR) begin
                                ctl_d.rw = ctl_q.sh[0];
                                ctl_d.oe = 1'b1;
                                ctl_d.st = ST_ADDR_ACK;
                            end else begin
                                ctl_d.st = ST_IDLE;
                            end
                        end else if (ctl_q.st == ST_CMD) begin
                            ctl_d.ptr = ctl_q.sh;
                            ctl_d.oe  = 1'b1;
                            ctl_d.st  = ST_CMD_ACK;
                        end else begin
                            wr_en     = (ctl_q.ptr < 8'(NUM_REGS));
                            ctl_d.ptr = ptr_next(ctl_q.ptr, NUM_REGS);
                            ctl_d.oe  = 1'b1;
                            ctl_d.st  = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (ctl_q.rw) begin
                            ctl_d.sh   = rd_data;
                            ctl_d.ptr  = ptr_next(ctl_q.ptr, NUM_REGS);
                            ctl_d.oe   = ~rd_data[7];
                            ctl_d.bits = '0;
                            ctl_d.st   = ST_RDATA;
                        end else begin
                            ctl_d.oe = 1'b0;
                            ctl_d.st = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        ctl_d.oe = 1'b0;
                        ctl_d.st = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (ctl_q.bits == 3'd7) begin
                            ctl_d.oe   = 1'b0;
                            ctl_d.bits = '0;
                            ctl_d.st   = ST_RACK;
                        end else begin
                            ctl_d.sh   = {ctl_q.sh[6:0], 1'b0};
                            ctl_d.oe   = ~ctl_q.sh[6];
                            ctl_d.bits = ctl_q.bits + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ctl_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (!ctl_q.nack) begin
                            ctl_d.sh   = rd_data;
                            ctl_d.ptr  = ptr_next(ctl_q.ptr, NUM_REGS);
                            ctl_d.oe   = ~rd_data[7];
                            ctl_d.bits = '0;
                            ctl_d.st   = ST_RDATA;
                        end else begin
                            ctl_d.oe = 1'b0;
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;
    assign in_rack  = (ctl_q.st == ST_RACK);
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_oe,
    input logic                  scl_s,
    input logic                  scl_fall,
    input logic                  stop_seen,
    input logic                  start_seen,
    input logic                  wd_expire,
    input logic                  cfg_en,
    input logic                  wr_en,
    input logic                  in_rack,
    input logic                  nack,
    input logic [NUM_REGS*8-1:0] regs
);
    // R3: drive only begins while the clock line is low
    assert_drive_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R3: STOP frees the data line
    assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !start_seen) |=> !sda_oe);

    // R4: registers change only through an accepted data byte
    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R9: master NACK frees the data line
    assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rack && scl_fall && nack && !start_seen) |=> !sda_oe);

    // R10: an abort frees the data line
    assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expire && !start_seen) |=> !sda_oe);

    // R12: no abort while the enable bit is clear
    assert_abort_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |-> cfg_en);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s), .scl_fall(scl_fall),
    .stop_seen(stop_seen), .start_seen(start_seen), .wd_expire(wd_expire),
    .cfg_en(cfg_en), .wr_en(wr_en), .in_rack(in_rack), .nack(ctl_q.nack), .regs(regs_o)
);

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
    localparam int         NR   = 8;
    localparam int         TO   = 300;
    localparam int         Q    = 10;
    localparam logic [6:0] DEV  = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    logic sda_line;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_reg_slave #(.DEV_ADDR(DEV), .NUM_REGS(NR), .TIMEOUT_CYCLES(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_v[$];
    string      exp_t[$];
    logic [7:0] obs_v[$];

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_v.push_back(v);
        exp_t.push_back(tag);
    endtask

    // Scoreboard monitor: compares each byte the master read with the next expectation
    always @(negedge clk) begin
        if (obs_v.size() != 0) begin
            logic [7:0] a;
            a = obs_v.pop_front();
            if (exp_v.size() == 0) chk(1'b0, "read without expectation", 64'(a), 64'h0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_v.pop_front();
                t = exp_t.pop_front();
                chk(a === e, t, 64'(a), 64'(e));
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = ~sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0;
        end
        wq(Q); sda_m = ~give_ack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
        obs_v.push_back(b);
    endtask

    task automatic write_seq(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2, input string tag);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R2 address ack", 64'(ack), 64'h1);
        send_byte(cmd, ack);         chk(ack, "R4 pointer byte ack", 64'(ack), 64'h1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);    chk(ack, tag, 64'(ack), 64'h1);
        end
        bus_stop();
    endtask

    // Reads n bytes from the current pointer, NACKs the last one, checks release (R9)
    task automatic read_seq(input int n);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, "R2 read address ack", 64'(ack), 64'h1);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1);
        wq(Q);
        chk(sda_oe == 1'b0, "R9 release after NACK", 64'(sda_oe), 64'h0);
        bus_stop();
    endtask

    function automatic logic [7:0] reg_of(input int i);
        return regs[i*8 +: 8];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ack;
        logic [NR*8-1:0] snap;
        wq(4); rst_n = 1'b1; wq(4);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 oe at reset", 64'(sda_oe), 64'h0);
        chk(regs == 64'h01, "R1 register reset values", regs, 64'h01);

        // R4 write with autoincrement
        write_seq(8'd2, 3, 8'hAA, 8'hBB, 8'hCC, "R4 data ack");
        chk(regs[47:16] == 32'h00CCBBAA, "R4 regs 2..4", 64'(regs[47:16]), 64'hCCBBAA);
        write_seq(8'd5, 1, 8'h5A, 8'h00, 8'h00, "R4 data ack");
        chk(reg_of(5) == 8'h5A, "R4 reg5", 64'(reg_of(5)), 64'h5A);

        // R5 pointer-only write, then R6 read from the stored pointer
        snap = regs;
        write_seq(8'd2, 0, 8'h00, 8'h00, 8'h00, "R5 none");
        chk(regs == snap, "R5 no register change", regs, snap);
        expect_byte(8'hAA, "R6 read at pointer");
        expect_byte(8'hBB, "R6 read increment");
        expect_byte(8'hCC, "R6 read increment");
        read_seq(3);
        expect_byte(8'h5A, "R6 pointer persists");
        read_seq(1);

        // R2 wrong address ignored until START
        snap = regs;
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, ack); chk(!ack, "R2 foreign address no ack", 64'(ack), 64'h0);
        send_byte(8'h00, ack);               chk(!ack, "R2 ignored byte no ack", 64'(ack), 64'h0);
        bus_stop();
        chk(regs == snap, "R2 no register change", regs, snap);

        // R7 wrap on write and on read
        write_seq(8'd7, 2, 8'h77, 8'h21, 8'h00, "R7 data ack");
        chk(reg_of(7) == 8'h77 && reg_of(0) == 8'h21, "R7 write wrap", 64'({reg_of(7), reg_of(0)}), 64'h7721);
        write_seq(8'd7, 0, 8'h00, 8'h00, 8'h00, "R7 none");
        expect_byte(8'h77, "R7 read last");
        expect_byte(8'h21, "R7 read wrapped");
        read_seq(2);

        // R8 unimplemented address
        snap = regs;
        write_seq(8'h30, 1, 8'h99, 8'h00, 8'h00, "R8 discarded byte ack");
        chk(regs == snap, "R8 no register change", regs, snap);
        write_seq(8'h30, 0, 8'h00, 8'h00, 8'h00, "R8 none");
        expect_byte(8'h00, "R8 read zero");
        expect_byte(8'h21, "R8 wrap to 0");
        read_seq(2);

        // R10 / R11 abort while driving a zero in a read
        write_seq(8'd6, 0, 8'h00, 8'h00, 8'h00, "R10 none");
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, "R10 address ack", 64'(ack), 64'h1);
        wq(4);
        chk(sda_oe == 1'b1, "R10 driving before stall", 64'(sda_oe), 64'h1);
        wq(TO + 20);
        chk(sda_oe == 1'b0, "R10 released after stall", 64'(sda_oe), 64'h0);
        expect_byte(8'hFF, "R11 bus ignored after abort");
        recv_byte(1'b0);
        chk(sda_oe == 1'b0, "R11 no drive after abort", 64'(sda_oe), 64'h0);
        bus_stop();

        // R11 abort in a write: later byte not taken
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R11 address ack", 64'(ack), 64'h1);
        send_byte(8'd3, ack);        chk(ack, "R11 pointer ack", 64'(ack), 64'h1);
        wq(TO + 20);
        send_byte(8'h11, ack);       chk(!ack, "R11 no ack after abort", 64'(ack), 64'h0);
        bus_stop();
        chk(reg_of(3) == 8'hBB, "R11 reg3 unchanged", 64'(reg_of(3)), 64'hBB);

        // R12 watchdog disabled
        write_seq(8'd0, 1, 8'h20, 8'h00, 8'h00, "R12 cfg ack");
        write_seq(8'd6, 0, 8'h00, 8'h00, 8'h00, "R12 none");
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, "R12 address ack", 64'(ack), 64'h1);
        wq(TO + 50);
        chk(sda_oe == 1'b1, "R12 still driving", 64'(sda_oe), 64'h1);
        expect_byte(8'h00, "R12 byte after long stall");
        recv_byte(1'b0);
        bus_stop();
        write_seq(8'd0, 1, 8'h21, 8'h00, 8'h00, "R12 cfg ack");

        // R13 START around watchdog expiry
        for (int off = -3; off <= 3; off++) begin
            bus_start();
            send_byte({DEV, 1'b0}, ack); chk(ack, "R13 address ack", 64'(ack), 64'h1);
            send_byte(8'd4, ack);        chk(ack, "R13 pointer ack", 64'(ack), 64'h1);
            sda_m = 1'b1; scl_m = 1'b1;
            wq(TO - 1 + off);
            sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
            send_byte({DEV, 1'b1}, ack); chk(ack, "R13 restart ack", 64'(ack), 64'h1);
            expect_byte(8'hCC, "R13 read after restart");
            recv_byte(1'b0);
            bus_stop();
        end

        wq(20);
        chk(exp_v.size() == 0, "R6 all expected bytes read", 64'(exp_v.size()), 64'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule